// File: doc/BRIEF.md
# Low-Power DDR Power-Up Initialization Sequencer

This block takes a low-power DDR1 memory from power-up to normal operation with no software involved. A start pulse begins the run. The sequencer first holds every memory-facing output idle for a stabilization period, with clock enable low and the command bus at NOP. It then raises clock enable and issues the fixed bring-up order as one-cycle command strobes on a plain command/bank/row-address interface: NOP, precharge of all banks, two auto-refresh commands, an extended mode register load and a standard mode register load. Each command is followed by a counted gap. The values loaded into the mode registers are built from field inputs.

When the sequence is complete, `done_o` goes high and stays high. A periodic refresh-request timer then runs. It pulses `ref_req_o` once every refresh period, and the memory controller that owns the bus after start-up consumes that pulse. `mode_o` shows the current phase using a fixed numeric code. All delays are given in clock cycles through parameters. The defaults are derived from the clock frequency: 200 µs of stabilization and a 15.625 µs refresh interval at 100 MHz, which gives a count of 1562.

Top module: `lpddr_init_seq`

## Requirements
- R1: While reset is active and afterwards until a start pulse arrives: `cke_o`=0, `done_o`=0, `ref_req_o`=0, `mode_o`=0, `cmd_o`=1 (NOP), `ba_o`=0, `addr_o`=0.
- R2: After `start_i` is sampled high in the idle state, the next STAB_CYC cycles keep `cke_o`=0 and `cmd_o`=1, with `mode_o`=1.
- R3: Counting the cycle after the start edge as cycle 1, with P=STAB_CYC: NOP at cycle P+1 and precharge at P+2. The first auto-refresh follows T_RP cycles later, the second follows T_RFC cycles later, the extended mode register load follows T_RFC cycles later, the standard mode register load follows T_MRD cycles later, and `done_o` rises T_MRD cycles after that.
- R4: `mode_o` reports the phase with these codes: 0 normal/idle, 1 stabilize and NOP, 2 precharge plus its gap, 4 auto-refresh plus its gaps, 5 extended load plus its gap, 3 standard load plus its gap.
- R5: The extended mode register load (`cmd_o`=5) drives `ba_o`=2'b10 and `addr_o`={0, ds[2:0] at bits 7:5, tcsr[1:0] at bits 4:3, pasr[2:0] at bits 2:0}.
- R6: The standard mode register load (`cmd_o`=3) drives `ba_o`=2'b00 and `addr_o`={0, cl[2:0] at bits 6:4, 0 at bit 3, bl[2:0] at bits 2:0}.
- R7: A run issues exactly two auto-refresh strobes (`cmd_o`=4), and both come before the extended mode register load.
- R8: The precharge strobe (`cmd_o`=2) drives `addr_o` bit 10 high, all other address bits low, and `ba_o`=0.
- R9: Every command is a one-cycle strobe. Every other cycle drives `cmd_o`=1 with `ba_o`=0 and `addr_o`=0.
- R10: `done_o` stays high until reset. A start pulse that arrives while a run is in progress or after it has finished has no effect on any output.
- R11: `ref_req_o` is low until `done_o` is high. Its first one-cycle pulse comes REF_CYC-1 cycles after the first cycle with `done_o` high, and further pulses follow every REF_CYC cycles.
- R12: `cke_o` rises in the NOP cycle and does not fall again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cl_i | input | 3 | CAS latency field for the standard mode register |
| bl_i | input | 3 | Burst length field for the standard mode register |
| tcsr_i | input | 2 | Temperature-compensated self refresh field |
| pasr_i | input | 3 | Partial array self refresh field |
| ds_i | input | 3 | Drive strength field |
| cke_o | output | 1 | Memory clock enable |
| cmd_o | output | 3 | Command code; NOP (1) between strobes |
| ba_o | output | 2 | Bank address |
| addr_o | output | ROW_W | Row address |
| mode_o | output | 3 | Current phase code |
| done_o | output | 1 | Initialization complete |
| ref_req_o | output | 1 | Periodic refresh request pulse |

## Verification
The assertions assume that the mode-register field inputs stay stable from start until `done_o`, and that `start_i` is a clean synchronous level. The bench changes the field values only while reset is held, and drives `start_i` half a cycle away from the active edge. The gap parameters are assumed to be at least one, so that two strobes are never adjacent except for NOP followed by precharge. The bench uses small gap values that satisfy this. The bench sweeps eight field patterns, and each pattern is paired with a stray start pulse at a different point in the sequence, including the stabilization wait, a gap and the period after done.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

  typedef enum logic [2:0] {
    MC_NORMAL = 3'd0,
    MC_NOP    = 3'd1,
    MC_PREALL = 3'd2,
    MC_MRS    = 3'd3,
    MC_AREF   = 3'd4,
    MC_EMRS   = 3'd5
  } mode_code_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STAB, ST_NOP, ST_PRE, ST_TRP,
    ST_REF1, ST_TRFC1, ST_REF2, ST_TRFC2,
    ST_EMRS, ST_TMRD1, ST_MRS, ST_TMRD2, ST_DONE
  } seq_state_e;

endpackage

// File: rtl/lpddr_init_fsm.sv
module lpddr_init_fsm
  import lpddr_init_pkg::*;
#(
  parameter int STAB_CYC = 20000,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output seq_state_e state_o
);
  localparam int MAX_A = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int MAX_B = (MAX_A > T_MRD) ? MAX_A : T_MRD;
  localparam int MAX_C = (MAX_B > STAB_CYC) ? MAX_B : STAB_CYC;
  localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CW-1:0] LD_STAB = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RFC  = CW'(T_RFC - 1);
  localparam logic [CW-1:0] LD_MRD  = CW'(T_MRD - 1);

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          expired;

  assign expired = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) begin st_d = ST_STAB; cnt_d = LD_STAB; end
      ST_STAB:  if (expired) st_d = ST_NOP;  else cnt_d = cnt_q - 1'b1;
      ST_NOP:   st_d = ST_PRE;
      ST_PRE:   begin st_d = ST_TRP;   cnt_d = LD_RP;  end
      ST_TRP:   if (expired) st_d = ST_REF1; else cnt_d = cnt_q - 1'b1;
      ST_REF1:  begin st_d = ST_TRFC1; cnt_d = LD_RFC; end
      ST_TRFC1: if (expired) st_d = ST_REF2; else cnt_d = cnt_q - 1'b1;
      ST_REF2:  begin st_d = ST_TRFC2; cnt_d = LD_RFC; end
      ST_TRFC2: if (expired) st_d = ST_EMRS; else cnt_d = cnt_q - 1'b1;
      ST_EMRS:  begin st_d = ST_TMRD1; cnt_d = LD_MRD; end
      ST_TMRD1: if (expired) st_d = ST_MRS;  else cnt_d = cnt_q - 1'b1;
      ST_MRS:   begin st_d = ST_TMRD2; cnt_d = LD_MRD; end
      ST_TMRD2: if (expired) st_d = ST_DONE; else cnt_d = cnt_q - 1'b1;
      ST_DONE:  st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/lpddr_init_cmdgen.sv
module lpddr_init_cmdgen
  import lpddr_init_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  seq_state_e       state_i,
  input  logic [2:0]       cl_i,
  input  logic [2:0]       bl_i,
  input  logic [1:0]       tcsr_i,
  input  logic [2:0]       pasr_i,
  input  logic [2:0]       ds_i,
  output logic             cke_o,
  output logic [2:0]       cmd_o,
  output logic [1:0]       ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic [2:0]       mode_o
);
  localparam int A10 = 10;

  always_comb begin
    cmd_o  = MC_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    cke_o  = !(state_i == ST_IDLE || state_i == ST_STAB);
    unique case (state_i)
      ST_PRE: begin
        cmd_o       = MC_PREALL;
        addr_o[A10] = 1'b1;
      end
      ST_REF1, ST_REF2: cmd_o = MC_AREF;
      ST_EMRS: begin
        cmd_o       = MC_EMRS;
        ba_o        = 2'b10;
        addr_o[7:0] = {ds_i, tcsr_i, pasr_i};
      end
      ST_MRS: begin
        cmd_o       = MC_MRS;
        addr_o[6:0] = {cl_i, 1'b0, bl_i};
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (state_i)
      ST_STAB, ST_NOP:                      mode_o = MC_NOP;
      ST_PRE, ST_TRP:                       mode_o = MC_PREALL;
      ST_REF1, ST_TRFC1, ST_REF2, ST_TRFC2: mode_o = MC_AREF;
      ST_EMRS, ST_TMRD1:                    mode_o = MC_EMRS;
      ST_MRS, ST_TMRD2:                     mode_o = MC_MRS;
      default:                              mode_o = MC_NORMAL;
    endcase
  end

endmodule

// File: rtl/lpddr_ref_timer.sv
module lpddr_ref_timer #(
  parameter int REF_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic req_o
);
  localparam int RW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;
  localparam logic [RW-1:0] RELOAD = RW'(REF_CYC - 1);

  logic [RW-1:0] rcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rcnt_q <= RELOAD;
    else if (!run_i)          rcnt_q <= RELOAD;
    else if (rcnt_q == '0)    rcnt_q <= RELOAD;
    else                      rcnt_q <= rcnt_q - 1'b1;
  end

  assign req_o = run_i && (rcnt_q == '0);

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int STAB_US  = 200,
  parameter int REF_NS   = 15625,
  parameter int ROW_W    = 13,
  parameter int STAB_CYC = STAB_US * CLK_MHZ,
  parameter int REF_CYC  = (REF_NS * CLK_MHZ) / 1000,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       cl_i,
  input  logic [2:0]       bl_i,
  input  logic [1:0]       tcsr_i,
  input  logic [2:0]       pasr_i,
  input  logic [2:0]       ds_i,
  output logic             cke_o,
  output logic [2:0]       cmd_o,
  output logic [1:0]       ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic [2:0]       mode_o,
  output logic             done_o,
  output logic             ref_req_o
);
  seq_state_e state;

  lpddr_init_fsm #(
    .STAB_CYC(STAB_CYC), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_o(state)
  );

  lpddr_init_cmdgen #(.ROW_W(ROW_W)) u_cmd (
    .state_i(state), .cl_i(cl_i), .bl_i(bl_i), .tcsr_i(tcsr_i),
    .pasr_i(pasr_i), .ds_i(ds_i), .cke_o(cke_o), .cmd_o(cmd_o),
    .ba_o(ba_o), .addr_o(addr_o), .mode_o(mode_o)
  );

  assign done_o = (state == ST_DONE);

  lpddr_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk(clk), .rst_n(rst_n), .run_i(done_o), .req_o(ref_req_o)
  );

endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke_o,
  input logic [2:0]       cmd_o,
  input logic [1:0]       ba_o,
  input logic [ROW_W-1:0] addr_o,
  input logic             done_o,
  input logic             ref_req_o
);
  logic [1:0] aref_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              aref_seen <= 2'd0;
    else if (cmd_o == 3'd4 && aref_seen != 2'd3) aref_seen <= aref_seen + 2'd1;
  end

  AST_CKE_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$fell(cke_o)); // R12
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o != 3'd1) |-> cke_o); // R12
  AST_EMRS_BANK: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o == 3'd5) |-> (ba_o == 2'b10)); // R5
  AST_MRS_BANK: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o == 3'd3) |-> (ba_o == 2'b00)); // R6
  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o == 3'd2) |-> addr_o[10]); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o != 3'd1) |=> (cmd_o == 3'd1)); // R9
  AST_TWO_AREF: assert property (@(posedge clk) disable iff (!rst_n) (cmd_o == 3'd5) |-> (aref_seen == 2'd2)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> done_o); // R10
  AST_REF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) ref_req_o |-> done_o); // R11
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ref_req_o |=> !ref_req_o); // R11

endmodule

bind lpddr_init_seq lpddr_init_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_o(cke_o), .cmd_o(cmd_o), .ba_o(ba_o),
  .addr_o(addr_o), .done_o(done_o), .ref_req_o(ref_req_o)
);

// File: tb/sim_lpddr_init_seq.sv
`timescale 1ns/1ps
module sim_lpddr_init_seq;
  localparam int P    = 8;
  localparam int TRP  = 2;
  localparam int TRFC = 3;
  localparam int TMRD = 2;
  localparam int REFC = 6;
  localparam int RW   = 13;

  localparam int T_NOP = P + 1;
  localparam int T_PRE = P + 2;
  localparam int T_R1  = T_PRE + TRP + 1;
  localparam int T_R2  = T_R1 + TRFC + 1;
  localparam int T_E   = T_R2 + TRFC + 1;
  localparam int T_M   = T_E + TMRD + 1;
  localparam int T_D   = T_M + TMRD + 1;
  localparam int NCYC  = T_D + 3 * REFC + 2;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [2:0] cl_i = '0, bl_i = '0, pasr_i = '0, ds_i = '0;
  logic [1:0] tcsr_i = '0;
  logic cke_o, done_o, ref_req_o;
  logic [2:0] cmd_o, mode_o;
  logic [1:0] ba_o;
  logic [RW-1:0] addr_o;

  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  lpddr_init_seq #(
    .ROW_W(RW), .STAB_CYC(P), .REF_CYC(REFC), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cl_i(cl_i), .bl_i(bl_i),
    .tcsr_i(tcsr_i), .pasr_i(pasr_i), .ds_i(ds_i), .cke_o(cke_o), .cmd_o(cmd_o),
    .ba_o(ba_o), .addr_o(addr_o), .mode_o(mode_o), .done_o(done_o), .ref_req_o(ref_req_o)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "R3", "watchdog", cyc, 100000);
      finish_run();
    end
  end

  function automatic int exp_mode(input int k);
    if (k <= T_NOP) return 1;
    if (k < T_R1)   return 2;
    if (k < T_E)    return 4;
    if (k < T_M)    return 5;
    if (k < T_D)    return 3;
    return 0;
  endfunction

  function automatic int exp_cmd(input int k);
    if (k == T_PRE) return 2;
    if (k == T_R1 || k == T_R2) return 4;
    if (k == T_E) return 5;
    if (k == T_M) return 3;
    return 1;
  endfunction

  function automatic int exp_addr(input int k);
    if (k == T_PRE) return 1024;
    if (k == T_E)   return ds_i * 32 + tcsr_i * 8 + pasr_i;
    if (k == T_M)   return cl_i * 16 + bl_i;
    return 0;
  endfunction

  task automatic check_idle(input string tag);
    chk(cke_o == 1'b0, tag, "cke", cke_o, 0);
    chk(done_o == 1'b0, tag, "done", done_o, 0);
    chk(ref_req_o == 1'b0, tag, "ref_req", ref_req_o, 0);
    chk(mode_o == 3'd0, tag, "mode", mode_o, 0);
    chk(cmd_o == 3'd1 && ba_o == 2'd0 && addr_o == '0, tag, "cmd/ba/addr", cmd_o, 1);
  endtask

  task automatic run_one(input int r, input int inj);
    int arefs;
    rst_n = 1'b0;
    cl_i = 3'(r); bl_i = 3'(7 - r); tcsr_i = 2'(r); pasr_i = 3'(r ^ 5); ds_i = 3'((r * 3) & 7);
    repeat (2) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    arefs = 0;
    for (int k = 1; k <= NCYC; k++) begin
      int ecmd, eba;
      bit eref;
      ecmd = exp_cmd(k);
      eba  = (k == T_E) ? 2 : 0;
      eref = (k >= T_D) && (((k - T_D) % REFC) == REFC - 1);
      if (cmd_o == 3'd4) arefs++;
      chk(cke_o == (k >= T_NOP), (k < T_NOP) ? "R2" : "R12", "cke", cke_o, int'(k >= T_NOP));
      chk(int'(mode_o) == exp_mode(k), "R4", "mode", mode_o, exp_mode(k));
      chk(int'(cmd_o) == ecmd, (ecmd == 1) ? "R9" : "R3", "cmd", cmd_o, ecmd);
      chk(int'(ba_o) == eba, (k == T_E) ? "R5" : "R6", "ba", ba_o, eba);
      chk(int'(addr_o) == exp_addr(k), (k == T_E) ? "R5" : (k == T_PRE) ? "R8" : "R6",
          "addr", addr_o, exp_addr(k));
      chk(done_o == (k >= T_D), "R10", "done", done_o, int'(k >= T_D));
      chk(ref_req_o == eref, "R11", "ref_req", ref_req_o, int'(eref));
      start_i = (k == inj);
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(arefs == 2, "R7", "auto-refresh count", arefs, 2);
  endtask

  initial begin
    int injs[8] = '{3, 9, 11, 14, 19, 24, 28, 35};
    for (int r = 0; r < 8; r++) run_one(r, injs[r]);
    finish_run();
  end

endmodule